// File: doc/BRIEF.md
# Display Link Bring-Up Sequencer

This block steps a display sink, reached over a serial display link, from power-off to live video. It turns on the panel rails, waits for them to settle, holds and then releases the sink reset, lets the link reach its low-power stop state, starts an external command engine that sends the initialization envelope, and finally checks a number of frame boundaries before declaring video good. Every step has a precondition, a programmable guard time and a pass test.

It also covers the paths that leave steady video. A sleep request waits for the frame in flight to finish before it enters the ultra-low-power state. A resume waits for link readiness and a guard time, then re-sends the same initialization envelope. A failure resets only the PHY, re-establishes transport, re-initializes and re-validates. The sequencer counts consecutive recovery attempts and parks in a fault state once the cap is reached. A warm restart, a cold boot and a loss of rail power all re-enter through the same rail and reset gates. Guard times, the init timeout, the retry cap and the number of validation frames are inputs, so firmware can set them at run time.

Top module: `disp_bringup_seq`

## Requirements
- R1: The `state` output encodes OFF=0, RAILS=1, RST_HOLD=2, RST_REL=3, LP_RDY=4, INIT=5, VALIDATE=6, VIDEO=7, DRAIN=8, SLEEP=9, RESUME=10, RECOVER=11 and FAULT=12. After reset the block is in OFF. A cold boot then runs OFF, RAILS, RST_HOLD, RST_REL, LP_RDY, INIT, VALIDATE and VIDEO in that order, and OFF always moves to RAILS on the next cycle.
- R2: RAILS moves to RST_HOLD only when `pwr_good` has been high for `rail_stable_cyc` consecutive cycles. A low cycle restarts that count. RST_HOLD then lasts `reset_hold_cyc` cycles before RST_REL.
- R3: RST_REL lasts `guard_cyc` cycles with the sink reset released. LP_RDY then waits for `lane_idle`, so INIT starts at least `guard_cyc`+1 cycles after release.
- R4: `init_start` is high for the whole of INIT. If `init_done` is seen, the block moves to VALIDATE. If `init_done` is not seen within `init_timeout_cyc` cycles of INIT, this is a failure.
- R5: In VALIDATE, video is enabled. When `stable_frames` consecutive `frame_tick` pulses arrive with `sink_ok` high, the block moves to VIDEO. A `frame_tick` with `sink_ok` low is a failure.
- R6: In VIDEO, `fault_req` is a failure and takes priority over `sleep_req`. `sleep_req` moves the block to DRAIN, where video stays on until the next `frame_tick`. The block then enters SLEEP with video off and `ulps_en` high.
- R7: In SLEEP, `wake_req` moves the block to RESUME. RESUME needs `guard_cyc` consecutive cycles with `lane_idle` high, then enters INIT and follows the same path as a cold boot.
- R8: A failure enters RECOVER. RECOVER holds the PHY reset for `reset_hold_cyc` cycles while the sink reset stays released, then moves to LP_RDY, then INIT and VALIDATE.
- R9: `retry_cnt` rises by one on each entry to RECOVER. It clears when VALIDATE passes and on restart. If a failure occurs while `retry_cnt` equals `max_retry`, the block enters FAULT instead of RECOVER. FAULT has video off, rails on and both resets asserted, and it stays there until `restart_req`.
- R10: If `pwr_good` is low in any state other than OFF, RAILS or FAULT, the next state is RAILS. That state has the sink reset asserted and a fresh rail-stable count.
- R11: `restart_req` moves the block from any state to OFF on the next cycle, which then leads into the cold-boot path.
- R12: `init_cnt` rises by one, wrapping, on every entry to INIT.
- R13: Outputs decode from the state. `rail_en` is high in every state except OFF. `sink_rst_n` is high in states 3 to 11. `phy_rst` is high in states 0 to 3, in 11 and in 12. `video_en` is high in states 6 to 8. `ulps_en` is high only in state 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Panel rails are in regulation |
| lane_idle | input | 1 | Link lanes are in the low-power stop state |
| init_done | input | 1 | Command engine has finished the init envelope |
| sink_ok | input | 1 | Sink responded and the frame was good |
| frame_tick | input | 1 | One-cycle frame-boundary strobe |
| sleep_req | input | 1 | Request to enter low-power sleep |
| wake_req | input | 1 | Request to leave sleep |
| fault_req | input | 1 | External error report; starts recovery |
| restart_req | input | 1 | Warm restart from any state |
| rail_stable_cyc | input | TW | Cycles of continuous power-good needed (at least 1) |
| reset_hold_cyc | input | TW | Cycles for which the sink or PHY reset is held (at least 1) |
| guard_cyc | input | TW | Guard after reset release and on resume (at least 1) |
| init_timeout_cyc | input | TW | Cycles allowed for the init envelope (at least 1) |
| max_retry | input | CW | Consecutive recoveries allowed before FAULT |
| stable_frames | input | CW | Good frames needed to pass validation (at least 1) |
| rail_en | output | 1 | Rail enable |
| sink_rst_n | output | 1 | Sink reset, active low |
| phy_rst | output | 1 | PHY and link reset |
| init_start | output | 1 | Init envelope request, held through INIT |
| video_en | output | 1 | Video stream enable |
| ulps_en | output | 1 | Ultra-low-power state request |
| state | output | 4 | Current state code |
| retry_cnt | output | CW | Consecutive recovery attempts |
| init_cnt | output | NW | Init envelopes started |

## Verification
The sequencer is driven through a cold boot with a power-good glitch during rail wait, then through sleep and wake, an injected fault, and validation with a sink that never answers. The glitch shows that the rail count is consecutive rather than cumulative. Sleep and wake show that a resume re-sends the same envelope. The silent sink runs the retry counter up to its cap and into FAULT. A stalled command engine times out INIT twice and reaches FAULT by a separate route. A rail drop during video shows the return to the reset gate, and a restart shows warm reboot through the same gates. The timings from rail restore to reset release, and from release to init start, are measured in cycles against the programmed values.

// File: rtl/disp_bringup_seq.sv
module disp_bringup_seq #(
  parameter int TW = 16,
  parameter int CW = 4,
  parameter int NW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_good,
  input  logic          lane_idle,
  input  logic          init_done,
  input  logic          sink_ok,
  input  logic          frame_tick,
  input  logic          sleep_req,
  input  logic          wake_req,
  input  logic          fault_req,
  input  logic          restart_req,
  input  logic [TW-1:0] rail_stable_cyc,
  input  logic [TW-1:0] reset_hold_cyc,
  input  logic [TW-1:0] guard_cyc,
  input  logic [TW-1:0] init_timeout_cyc,
  input  logic [CW-1:0] max_retry,
  input  logic [CW-1:0] stable_frames,
  output logic          rail_en,
  output logic          sink_rst_n,
  output logic          phy_rst,
  output logic          init_start,
  output logic          video_en,
  output logic          ulps_en,
  output logic [3:0]    state,
  output logic [CW-1:0] retry_cnt,
  output logic [NW-1:0] init_cnt
);

  localparam logic [3:0] S_OFF   = 4'd0;
  localparam logic [3:0] S_RAILS = 4'd1;
  localparam logic [3:0] S_HOLD  = 4'd2;
  localparam logic [3:0] S_REL   = 4'd3;
  localparam logic [3:0] S_LPRDY = 4'd4;
  localparam logic [3:0] S_INIT  = 4'd5;
  localparam logic [3:0] S_VALID = 4'd6;
  localparam logic [3:0] S_VIDEO = 4'd7;
  localparam logic [3:0] S_DRAIN = 4'd8;
  localparam logic [3:0] S_SLEEP = 4'd9;
  localparam logic [3:0] S_RESUM = 4'd10;
  localparam logic [3:0] S_RECOV = 4'd11;
  localparam logic [3:0] S_FAULT = 4'd12;
  localparam logic [TW-1:0] TMR_MAX = '1;

  logic [3:0]    st, nx;
  logic [TW-1:0] tmr;
  logic [CW-1:0] fcnt;
  logic          powered, capped, leaving;
  logic [3:0]    fail_dst;

  function automatic logic hit(input logic [TW-1:0] t, input logic [TW-1:0] lim);
    return t == lim - TW'(1);
  endfunction

  assign powered  = !(st == S_OFF || st == S_RAILS || st == S_FAULT);
  assign capped   = retry_cnt == max_retry;
  assign fail_dst = capped ? S_FAULT : S_RECOV;
  assign leaving  = nx != st;

  always_comb begin
    nx = st;
    if (restart_req) nx = S_OFF;
    else if (powered && !pwr_good) nx = S_RAILS;
    else begin
      case (st)
        S_OFF:   nx = S_RAILS;
        S_RAILS: if (pwr_good && hit(tmr, rail_stable_cyc)) nx = S_HOLD;
        S_HOLD:  if (hit(tmr, reset_hold_cyc)) nx = S_REL;
        S_REL:   if (hit(tmr, guard_cyc)) nx = S_LPRDY;
        S_LPRDY: if (lane_idle) nx = S_INIT;
        S_INIT: begin
          if (init_done) nx = S_VALID;
          else if (hit(tmr, init_timeout_cyc)) nx = fail_dst;
        end
        S_VALID: begin
          if (frame_tick) begin
            if (!sink_ok) nx = fail_dst;
            else if (fcnt + CW'(1) == stable_frames) nx = S_VIDEO;
          end
        end
        S_VIDEO: begin
          if (fault_req) nx = fail_dst;
          else if (sleep_req) nx = S_DRAIN;
        end
        S_DRAIN: if (frame_tick) nx = S_SLEEP;
        S_SLEEP: if (wake_req) nx = S_RESUM;
        S_RESUM: if (lane_idle && hit(tmr, guard_cyc)) nx = S_INIT;
        S_RECOV: if (hit(tmr, reset_hold_cyc)) nx = S_LPRDY;
        S_FAULT: nx = S_FAULT;
        default: nx = S_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= S_OFF;
    else        st <= nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr <= '0;
    else if (leaving) tmr <= '0;
    else if ((st == S_RAILS && !pwr_good) || (st == S_RESUM && !lane_idle)) tmr <= '0;
    else if (tmr != TMR_MAX) tmr <= tmr + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fcnt <= '0;
    else if (leaving) fcnt <= '0;
    else if (st == S_VALID && frame_tick && sink_ok) fcnt <= fcnt + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) retry_cnt <= '0;
    else if (nx == S_OFF) retry_cnt <= '0;
    else if (st == S_VALID && nx == S_VIDEO) retry_cnt <= '0;
    else if (nx == S_RECOV && st != S_RECOV) retry_cnt <= retry_cnt + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) init_cnt <= '0;
    else if (nx == S_INIT && st != S_INIT) init_cnt <= init_cnt + NW'(1);
  end

  assign state      = st;
  assign rail_en    = st != S_OFF;
  assign sink_rst_n = st >= S_REL && st <= S_RECOV;
  assign phy_rst    = st <= S_REL || st == S_RECOV || st == S_FAULT;
  assign init_start = st == S_INIT;
  assign video_en   = st == S_VALID || st == S_VIDEO || st == S_DRAIN;
  assign ulps_en    = st == S_SLEEP;

endmodule

// File: rtl/disp_bringup_seq_chk.sv
module disp_bringup_seq_chk #(
  parameter int TW = 16,
  parameter int CW = 4,
  parameter int NW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pwr_good,
  input logic          init_done,
  input logic          frame_tick,
  input logic          restart_req,
  input logic [TW-1:0] rail_stable_cyc,
  input logic [TW-1:0] guard_cyc,
  input logic [CW-1:0] max_retry,
  input logic          sink_rst_n,
  input logic          init_start,
  input logic          video_en,
  input logic          ulps_en,
  input logic [3:0]    state,
  input logic [CW-1:0] retry_cnt,
  input logic [NW-1:0] init_cnt
);

  logic [TW:0] pg_run, rel_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_run  <= '0;
      rel_run <= '0;
    end else begin
      pg_run  <= !pwr_good ? '0 : (pg_run == '1 ? pg_run : pg_run + 1'b1);
      rel_run <= !sink_rst_n ? '0 : (rel_run == '1 ? rel_run : rel_run + 1'b1);
    end
  end

  // R2
  rail_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sink_rst_n) |-> pg_run >= {1'b0, rail_stable_cyc});

  // R3
  init_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_start) |-> rel_run >= {1'b0, guard_cyc});

  // R5
  video_after_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(video_en) |-> $past(init_start) && $past(init_done));

  // R6
  sleep_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ulps_en) |-> $past(video_en) && $past(frame_tick));

  // R9
  retry_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retry_cnt <= max_retry);

  // R9
  fault_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == 4'd12 && !restart_req |=> state == 4'd12 && !video_en);

  // R10
  rail_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good && !restart_req && state != 4'd12 |=> !sink_rst_n && !video_en);

  // R11
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_req |=> state == 4'd0);

  // R12
  init_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_start) |-> init_cnt == NW'($past(init_cnt) + 1'b1));

endmodule

bind disp_bringup_seq disp_bringup_seq_chk #(.TW(TW), .CW(CW), .NW(NW)) chk_i (
  .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .init_done(init_done),
  .frame_tick(frame_tick), .restart_req(restart_req),
  .rail_stable_cyc(rail_stable_cyc), .guard_cyc(guard_cyc), .max_retry(max_retry),
  .sink_rst_n(sink_rst_n), .init_start(init_start), .video_en(video_en),
  .ulps_en(ulps_en), .state(state), .retry_cnt(retry_cnt), .init_cnt(init_cnt)
);

// File: tb/disp_bringup_seq_test.sv
module disp_bringup_seq_test;
  localparam int TW = 16, CW = 4, NW = 8;

  logic clk = 0;
  always #2 clk = ~clk;

  logic rst_n = 0;
  logic pwr_good = 0, lane_idle = 1, init_done = 0, sink_ok = 1, frame_tick = 0;
  logic sleep_req = 0, wake_req = 0, fault_req = 0, restart_req = 0;
  logic [TW-1:0] rail_stable_cyc = 16'd5, reset_hold_cyc = 16'd3, guard_cyc = 16'd4, init_timeout_cyc = 16'd10;
  logic [CW-1:0] max_retry = 4'd2, stable_frames = 4'd3;
  logic rail_en, sink_rst_n, phy_rst, init_start, video_en, ulps_en;
  logic [3:0] state;
  logic [CW-1:0] retry_cnt;
  logic [NW-1:0] init_cnt;

  disp_bringup_seq #(.TW(TW), .CW(CW), .NW(NW)) uut (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .lane_idle(lane_idle),
    .init_done(init_done), .sink_ok(sink_ok), .frame_tick(frame_tick),
    .sleep_req(sleep_req), .wake_req(wake_req), .fault_req(fault_req),
    .restart_req(restart_req), .rail_stable_cyc(rail_stable_cyc),
    .reset_hold_cyc(reset_hold_cyc), .guard_cyc(guard_cyc),
    .init_timeout_cyc(init_timeout_cyc), .max_retry(max_retry),
    .stable_frames(stable_frames), .rail_en(rail_en), .sink_rst_n(sink_rst_n),
    .phy_rst(phy_rst), .init_start(init_start), .video_en(video_en),
    .ulps_en(ulps_en), .state(state), .retry_cnt(retry_cnt), .init_cnt(init_cnt)
  );

  int checks = 0, errors = 0, cyc = 0, init_delay = 3, init_age = 0;
  bit done_flag = 0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run;
    if (!done_flag) begin
      done_flag = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Reference model: elapsed counters per state, integer state codes from R1
  int m_st = 0, m_t = 0, m_f = 0, m_rc = 0, m_ic = 0;
  always @(posedge clk) begin
    int nxt, fl;
    bit pw;
    if (!rst_n) begin
      m_st = 0; m_t = 0; m_f = 0; m_rc = 0; m_ic = 0;
    end else begin
      pw = !(m_st == 0 || m_st == 1 || m_st == 12);
      fl = (m_rc >= int'(max_retry)) ? 12 : 11;
      nxt = m_st;
      if (restart_req) nxt = 0;
      else if (pw && !pwr_good) nxt = 1;
      else case (m_st)
        0: nxt = 1;
        1: if (pwr_good && m_t + 1 >= int'(rail_stable_cyc)) nxt = 2;
        2: if (m_t + 1 >= int'(reset_hold_cyc)) nxt = 3;
        3: if (m_t + 1 >= int'(guard_cyc)) nxt = 4;
        4: if (lane_idle) nxt = 5;
        5: if (init_done) nxt = 6; else if (m_t + 1 >= int'(init_timeout_cyc)) nxt = fl;
        6: if (frame_tick) begin
             if (!sink_ok) nxt = fl;
             else if (m_f + 1 >= int'(stable_frames)) nxt = 7;
           end
        7: if (fault_req) nxt = fl; else if (sleep_req) nxt = 8;
        8: if (frame_tick) nxt = 9;
        9: if (wake_req) nxt = 10;
        10: if (lane_idle && m_t + 1 >= int'(guard_cyc)) nxt = 5;
        11: if (m_t + 1 >= int'(reset_hold_cyc)) nxt = 4;
        default: ;
      endcase
      if (nxt == 0) m_rc = 0;
      else if (m_st == 6 && nxt == 7) m_rc = 0;
      else if (nxt == 11 && m_st != 11) m_rc = m_rc + 1;
      if (nxt == 5 && m_st != 5) m_ic = (m_ic + 1) % 256;
      if (nxt != m_st) begin m_t = 0; m_f = 0; end
      else begin
        if ((m_st == 1 && !pwr_good) || (m_st == 10 && !lane_idle)) m_t = 0; else m_t++;
        if (m_st == 6 && frame_tick && sink_ok) m_f++;
      end
      m_st = nxt;
    end
  end

  function automatic logic [5:0] exp_out(int s);
    logic [5:0] o;
    o[5] = s != 0;                        // rail_en
    o[4] = s >= 3 && s <= 11;             // sink_rst_n
    o[3] = s <= 3 || s == 11 || s == 12;  // phy_rst
    o[2] = s == 5;                        // init_start
    o[1] = s >= 6 && s <= 8;              // video_en
    o[0] = s == 9;                        // ulps_en
    return o;
  endfunction

  // Environment drive (frame strobe, command engine) and per-cycle comparison
  always @(negedge clk) begin
    logic [5:0] e;
    cyc++;
    frame_tick = (cyc % 7) == 0;
    init_age = init_start ? init_age + 1 : 0;
    init_done = init_start && init_age >= init_delay;
    if (rst_n) begin
      e = exp_out(m_st);
      chk(int'(state) == m_st, "R1", "state", int'(state), m_st);
      chk({rail_en, sink_rst_n, phy_rst, init_start, video_en, ulps_en} == e, "R13", "outputs",
          int'({rail_en, sink_rst_n, phy_rst, init_start, video_en, ulps_en}), int'(e));
      chk(int'(retry_cnt) == m_rc, "R9", "retry_cnt", int'(retry_cnt), m_rc);
      chk(int'(init_cnt) == m_ic, "R12", "init_cnt", int'(init_cnt), m_ic);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "WATCHDOG", "cycles", 100000, 0);
    finish_run();
  end

  task automatic wait_state(int code, int maxc, string tag);
    int n = 0;
    while (int'(state) != code && n < maxc) begin @(negedge clk); n++; end
    chk(int'(state) == code, tag, "reach state", int'(state), code);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1; @(negedge clk); s = 0;
  endtask

  initial begin
    int k;
    repeat (3) @(negedge clk);
    chk(state == 4'd0 && !rail_en && !sink_rst_n && phy_rst, "R1", "reset state", int'(state), 0);
    rst_n = 1;
    repeat (6) @(negedge clk);
    chk(state == 4'd1, "R2", "waits without power-good", int'(state), 1);
    pwr_good = 1; repeat (3) @(negedge clk);
    pwr_good = 0; @(negedge clk);
    pwr_good = 1;
    k = 0;
    for (int i = 0; i < 50 && !sink_rst_n; i++) begin @(negedge clk); k++; end
    chk(k == 8, "R2", "restore-to-release cycles", k, 8);
    k = 0;
    for (int i = 0; i < 50 && !init_start; i++) begin @(negedge clk); k++; end
    chk(k == 5, "R3", "release-to-init cycles", k, 5);
    wait_state(7, 100, "R1");
    chk(init_cnt == 8'd1, "R12", "one envelope", int'(init_cnt), 1);

    pulse(sleep_req);
    wait_state(8, 5, "R6");
    chk(video_en, "R6", "video on while draining", int'(video_en), 1);
    wait_state(9, 20, "R6");
    chk(!video_en && ulps_en, "R6", "sleep outputs", int'({video_en, ulps_en}), 1);
    repeat (10) @(negedge clk);
    pulse(wake_req);
    wait_state(10, 5, "R7");
    wait_state(7, 100, "R7");
    chk(init_cnt == 8'd2, "R7", "resume re-sends envelope", int'(init_cnt), 2);

    pulse(fault_req);
    wait_state(11, 5, "R8");
    chk(phy_rst && sink_rst_n && retry_cnt == 4'd1, "R8", "recover outputs", int'({phy_rst, sink_rst_n}), 3);
    wait_state(7, 100, "R8");
    chk(retry_cnt == 4'd0, "R9", "cleared on validate", int'(retry_cnt), 0);

    sink_ok = 0;
    pulse(fault_req);
    wait_state(6, 60, "R5");
    wait_state(11, 20, "R5");
    chk(retry_cnt == 4'd2, "R5", "bad frame counted", int'(retry_cnt), 2);
    wait_state(12, 100, "R9");
    pulse(wake_req); pulse(sleep_req);
    repeat (20) @(negedge clk);
    chk(state == 4'd12 && !video_en && rail_en, "R9", "parked in fault", int'(state), 12);
    sink_ok = 1;

    pulse(restart_req);
    chk(state == 4'd0 && retry_cnt == 4'd0, "R11", "restart to off", int'(state), 0);
    wait_state(7, 100, "R11");

    init_delay = 100;
    pulse(fault_req);
    wait_state(5, 40, "R4");
    k = 0;
    while (state == 4'd5 && k < 50) begin @(negedge clk); k++; end
    chk(k == 10, "R4", "init timeout cycles", k, 10);
    chk(state == 4'd11, "R4", "timeout is failure", int'(state), 11);
    wait_state(12, 100, "R9");
    init_delay = 3;
    pulse(restart_req);
    wait_state(7, 100, "R11");

    @(negedge clk); pwr_good = 0;
    @(negedge clk);
    chk(state == 4'd1 && !sink_rst_n, "R10", "rail drop to rail wait", int'(state), 1);
    repeat (3) @(negedge clk);
    pwr_good = 1;
    wait_state(7, 100, "R10");
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule